// File: doc/BRIEF.md
# Cycle Sync Detector and Slot Timer

This block watches the received byte stream of a node on a cyclic real-time Ethernet ring. Only the frame that opens a communication cycle carries a short synchronization field, and that field is protected by its own CRC-8, separate from the frame FCS. When the field's check byte matches, the block raises a sync strike. The strike is held back by a programmed per-port delay so that every node on the ring lands on the same instant. The delayed strike is the timing reference.

The timing reference re-phases a cycle position counter. The counter runs at 10 ns resolution from a 100 MHz clock and has a 24-bit configured cycle length, so cycles from 31.25 µs (3125 counts) up to well over 100 ms fit. The counter's position splits each cycle into a real-time slot, which starts at the reference, and a best-effort slot for the rest of the cycle. It also drives a pulse window for an application coprocessor. A check byte that does not match is ignored, and the counter keeps free-running from the last good reference.

A lock flag gives the quality of the synchronization. Two references in a row set it. Three full cycles with no reference clear it.

Top module: `csync_top`

## Requirements
- R1: After reset, `sync_evt`, `cyc_pulse` and `locked` are low and `rt_slot` is high (position 0, with a non-zero real-time length).
- R2: A frame that starts with `rx_sof` and `rx_first` high carries its sync payload at byte positions 2 to 5 (position 0 is the byte with `rx_sof`) and a check byte at position 6. The check byte is CRC-8 over the payload: polynomial 0x07, initial value 0x00, MSB first, no final XOR. When the check byte matches, `sync_evt` pulses for one cycle.
- R3: A check byte that does not match produces no `sync_evt`, and the cycle position keeps free-running from the previous reference.
- R4: A frame whose `rx_sof` byte has `rx_first` low is never examined for a sync field.
- R5: `sync_evt` is high exactly `cfg_port_delay` + 1 cycles after the clock edge that takes in a matching check byte. A delay of 0 gives the event in the cycle right after that edge.
- R6: The cycle position is 0 in the cycle after `sync_evt`. It counts up by one each cycle and wraps to 0 after reaching `cfg_cycle_len` − 1.
- R7: `rt_slot` is high while the position is below `cfg_rt_len` and low for the rest of the cycle.
- R8: `cyc_pulse` is high while the position is at least `cfg_pulse_start` and below `cfg_pulse_start` + `cfg_pulse_width`.
- R9: `locked` rises in the cycle after the second of two references that have no natural wrap of the position between them. A single reference does not set it.
- R10: Three natural wraps in a row with no reference clear `locked`. It falls in the cycle after the third wrap edge.
- R11: A frame that ends (`rx_eof`) before its check byte produces no `sync_evt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz timer and stream clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_first | input | 1 | With `rx_sof`: this frame opens the cycle |
| cfg_cycle_len | input | 24 | Cycle length in clock counts |
| cfg_rt_len | input | 24 | Length of the real-time slot in counts |
| cfg_port_delay | input | 16 | Delay from sync strike to reference, in counts |
| cfg_pulse_start | input | 24 | Position where the coprocessor pulse starts |
| cfg_pulse_width | input | 24 | Width of the coprocessor pulse in counts |
| sync_evt | output | 1 | Timing reference strike, one cycle wide |
| rt_slot | output | 1 | High in the real-time slot, low in the best-effort slot |
| cyc_pulse | output | 1 | Cycle-synchronous pulse for the coprocessor |
| locked | output | 1 | Synchronization is established |

## Verification
There are two registers between the stream and the reference: the check-byte register and the delay counter. So when the bench drives a matching check byte, it computes the due cycle as one cycle past the driving edge plus the programmed delay, and puts that cycle in a queue. A monitor samples at the falling edge and pops one entry for each `sync_evt`. An event that has no entry in the queue is counted as a failure. The slot and pulse checks count from that reference: the position is 0 one cycle after the event, so a boundary at position p is sampled p + 1 cycles after the event. The lock flag is sampled on both sides of its due edge, which is one cycle after the second reference, or one cycle after the third wrap (three times the cycle length after the last reference).

// File: rtl/csync_pkg.sv
package csync_pkg;

  typedef enum logic [1:0] {
    DET_IDLE  = 2'd0,
    DET_TRACK = 2'd1,
    DET_SKIP  = 2'd2
  } det_state_e;

  localparam logic [7:0] CRC_POLY = 8'h07;

  // One byte through the CRC-8 register, whole byte folded in first.
  function automatic logic [7:0] crc8_step(input logic [7:0] crc_in,
                                           input logic [7:0] data);
    logic [7:0] r;
    r = crc_in ^ data;
    for (int b = 0; b < 8; b++) begin
      r = r[7] ? ((r << 1) ^ CRC_POLY) : (r << 1);
    end
    return r;
  endfunction

  // Position inside [start, start + width), written without overflow.
  function automatic logic in_window(input logic [31:0] pos,
                                     input logic [31:0] start,
                                     input logic [31:0] width);
    return (pos >= start) && ((pos - start) < width);
  endfunction

endpackage

// File: rtl/csync_detect.sv
module csync_detect
  import csync_pkg::*;
#(
  parameter int FIELD_OFS = 2,
  parameter int FIELD_LEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       rx_sof,
  input  logic       rx_eof,
  input  logic       rx_first,
  output logic       hit,
  output logic       bad
);
  localparam int CHK_POS = FIELD_OFS + FIELD_LEN;
  localparam int POS_W   = $clog2(CHK_POS + 2);

  det_state_e       st_q, st_d;
  logic [POS_W-1:0] pos_q, pos_d, cur_pos;
  logic [7:0]       crc_q, crc_d, crc_base;
  logic             track, hit_d, bad_d;

  always_comb begin
    cur_pos  = rx_sof ? '0 : pos_q;
    crc_base = rx_sof ? 8'h00 : crc_q;
    track    = rx_valid && (rx_sof ? rx_first : (st_q == DET_TRACK));
    st_d     = st_q;
    pos_d    = pos_q;
    crc_d    = crc_q;
    hit_d    = 1'b0;
    bad_d    = 1'b0;
    if (rx_valid) begin
      if (rx_sof) begin
        st_d  = rx_first ? DET_TRACK : DET_SKIP;
        pos_d = POS_W'(1);
        crc_d = 8'h00;
      end else if (st_q == DET_TRACK && pos_q <= POS_W'(CHK_POS)) begin
        pos_d = pos_q + 1'b1;
      end
      if (track) begin
        if (cur_pos >= POS_W'(FIELD_OFS) && cur_pos < POS_W'(CHK_POS)) begin
          crc_d = crc8_step(crc_base, rx_data);
        end
        if (cur_pos == POS_W'(CHK_POS)) begin
          hit_d = (rx_data == crc_base);
          bad_d = (rx_data != crc_base);
          st_d  = DET_SKIP;
        end
      end
      if (rx_eof) begin
        st_d = DET_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= DET_IDLE;
      pos_q <= '0;
      crc_q <= 8'h00;
      hit   <= 1'b0;
      bad   <= 1'b0;
    end else begin
      st_q  <= st_d;
      pos_q <= pos_d;
      crc_q <= crc_d;
      hit   <= hit_d;
      bad   <= bad_d;
    end
  end

endmodule

// File: rtl/csync_delay.sv
module csync_delay #(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic [DLY_W-1:0] delay,
  output logic             ref_evt
);
  logic             armed;
  logic [DLY_W-1:0] cnt;

  assign ref_evt = (hit && delay == '0) || (armed && cnt == DLY_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (hit) begin
      armed <= (delay != '0);
      cnt   <= delay;
    end else if (armed) begin
      cnt <= cnt - 1'b1;
      if (cnt == DLY_W'(1)) armed <= 1'b0;
    end
  end

endmodule

// File: rtl/csync_timer.sv
module csync_timer
  import csync_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_evt,
  input  logic [CNT_W-1:0] cycle_len,
  input  logic [CNT_W-1:0] rt_len,
  input  logic [CNT_W-1:0] pulse_start,
  input  logic [CNT_W-1:0] pulse_width,
  output logic [CNT_W-1:0] pos,
  output logic             wrap,
  output logic             rt_slot,
  output logic             pulse
);
  logic last;

  assign last    = (cycle_len == '0) || (pos >= cycle_len - 1'b1);
  assign wrap    = last && !ref_evt;
  assign rt_slot = (pos < rt_len);
  assign pulse   = in_window(32'(pos), 32'(pulse_start), 32'(pulse_width));

  always_ff @(posedge clk) begin
    if (!rst_n)       pos <= '0;
    else if (ref_evt) pos <= '0;
    else if (last)    pos <= '0;
    else              pos <= pos + 1'b1;
  end

endmodule

// File: rtl/csync_lock.sv
module csync_lock #(
  parameter int GOOD_N = 2,
  parameter int MISS_N = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_evt,
  input  logic wrap,
  output logic locked
);
  localparam int GW = $clog2(GOOD_N + 1);
  localparam int MW = $clog2(MISS_N + 1);

  logic [GW-1:0] good;
  logic [MW-1:0] miss;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      good   <= '0;
      miss   <= '0;
      locked <= 1'b0;
    end else if (ref_evt) begin
      miss <= '0;
      if (good < GW'(GOOD_N)) good <= good + 1'b1;
      if (good >= GW'(GOOD_N - 1)) locked <= 1'b1;
    end else if (wrap) begin
      good <= '0;
      if (miss < MW'(MISS_N)) miss <= miss + 1'b1;
      if (miss >= MW'(MISS_N - 1)) locked <= 1'b0;
    end
  end

endmodule

// File: rtl/csync_top.sv
module csync_top #(
  parameter int CNT_W     = 24,
  parameter int DLY_W     = 16,
  parameter int FIELD_OFS = 2,
  parameter int FIELD_LEN = 4,
  parameter int GOOD_N    = 2,
  parameter int MISS_N    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             rx_sof,
  input  logic             rx_eof,
  input  logic             rx_first,
  input  logic [CNT_W-1:0] cfg_cycle_len,
  input  logic [CNT_W-1:0] cfg_rt_len,
  input  logic [DLY_W-1:0] cfg_port_delay,
  input  logic [CNT_W-1:0] cfg_pulse_start,
  input  logic [CNT_W-1:0] cfg_pulse_width,
  output logic             sync_evt,
  output logic             rt_slot,
  output logic             cyc_pulse,
  output logic             locked
);
  // Named internal events for the checker.
  logic             sync_hit;
  logic             sync_bad;
  logic             ref_evt;
  logic [CNT_W-1:0] tmr_pos;
  logic             tmr_wrap;

  csync_detect #(.FIELD_OFS(FIELD_OFS), .FIELD_LEN(FIELD_LEN)) u_detect (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_first(rx_first),
    .hit(sync_hit), .bad(sync_bad)
  );

  csync_delay #(.DLY_W(DLY_W)) u_delay (
    .clk(clk), .rst_n(rst_n), .hit(sync_hit), .delay(cfg_port_delay),
    .ref_evt(ref_evt)
  );

  csync_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .ref_evt(ref_evt),
    .cycle_len(cfg_cycle_len), .rt_len(cfg_rt_len),
    .pulse_start(cfg_pulse_start), .pulse_width(cfg_pulse_width),
    .pos(tmr_pos), .wrap(tmr_wrap), .rt_slot(rt_slot), .pulse(cyc_pulse)
  );

  csync_lock #(.GOOD_N(GOOD_N), .MISS_N(MISS_N)) u_lock (
    .clk(clk), .rst_n(rst_n), .ref_evt(ref_evt), .wrap(tmr_wrap),
    .locked(locked)
  );

  assign sync_evt = ref_evt;

endmodule

// File: rtl/csync_checks.sv
module csync_checks #(
  parameter int CNT_W = 24,
  parameter int DLY_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_valid,
  input logic             sync_hit,
  input logic             sync_bad,
  input logic             sync_evt,
  input logic             rt_slot,
  input logic             locked,
  input logic             tmr_wrap,
  input logic [CNT_W-1:0] tmr_pos,
  input logic [CNT_W-1:0] cfg_cycle_len,
  input logic [CNT_W-1:0] cfg_rt_len,
  input logic [DLY_W-1:0] cfg_port_delay
);
  AST_HIT_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> !sync_hit);  // R2

  AST_BAD_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !(sync_hit && sync_bad));  // R3

  AST_ZERO_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_hit && cfg_port_delay == '0) |-> sync_evt);  // R5

  AST_REF_ZEROES_POS: assert property (@(posedge clk) disable iff (!rst_n)
    sync_evt |=> (tmr_pos == '0));  // R6

  AST_POS_BELOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(cfg_cycle_len) && cfg_cycle_len != '0 && $past(tmr_pos) < cfg_cycle_len)
      |-> (tmr_pos < cfg_cycle_len));  // R6

  AST_RT_FALL_AT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rt_slot) && $stable(cfg_rt_len)) |-> (tmr_pos == cfg_rt_len));  // R7

  AST_LOCK_RISE_ON_REF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(sync_evt));  // R9

  AST_LOCK_FALL_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(tmr_wrap));  // R10

endmodule

bind csync_top csync_checks #(.CNT_W(CNT_W), .DLY_W(DLY_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .sync_hit(sync_hit),
  .sync_bad(sync_bad), .sync_evt(sync_evt), .rt_slot(rt_slot),
  .locked(locked), .tmr_wrap(tmr_wrap), .tmr_pos(tmr_pos),
  .cfg_cycle_len(cfg_cycle_len), .cfg_rt_len(cfg_rt_len),
  .cfg_port_delay(cfg_port_delay)
);

// File: tb/tb_csync_top.sv
module tb_csync_top;
  localparam int CLK_PERIOD = 10;
  localparam int LEN = 200, RTL = 80, PST = 100, PWD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_first = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic [23:0] cfg_cycle_len = 24'(LEN), cfg_rt_len = 24'(RTL);
  logic [23:0] cfg_pulse_start = 24'(PST), cfg_pulse_width = 24'(PWD);
  logic [15:0] cfg_port_delay = 16'd0;
  logic        sync_evt, rt_slot, cyc_pulse, locked;

  int cyc = 0, checks = 0, errors = 0, unexp = 0, pd_now = 0, last_ref = 0;
  int exp_q[$];
  bit done = 1'b0;

  csync_top dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_first(rx_first),
    .cfg_cycle_len(cfg_cycle_len), .cfg_rt_len(cfg_rt_len),
    .cfg_port_delay(cfg_port_delay), .cfg_pulse_start(cfg_pulse_start),
    .cfg_pulse_width(cfg_pulse_width), .sync_evt(sync_evt),
    .rt_slot(rt_slot), .cyc_pulse(cyc_pulse), .locked(locked)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Bitwise CRC-8 (poly 0x07), one input bit at a time.
  function automatic logic [7:0] ref_crc(input logic [7:0] d [4]);
    logic [7:0] c = 8'h00;
    for (int k = 0; k < 4; k++)
      for (int i = 7; i >= 0; i--) begin
        logic fb;
        fb = c[7] ^ d[k][i];
        c  = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
      end
    return c;
  endfunction

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic at_cycle(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  // Driver: sends one frame and queues the expected reference cycle.
  task automatic send_frame(input bit first, input bit corrupt, input int nbytes,
                            input logic [7:0] seed);
    logic [7:0] pay [4];
    logic [7:0] chkb;
    for (int k = 0; k < 4; k++) pay[k] = seed + 8'(k * 37);
    chkb = ref_crc(pay) ^ (corrupt ? 8'h5A : 8'h00);
    for (int i = 0; i < nbytes; i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_sof   = (i == 0);
      rx_eof   = (i == nbytes - 1);
      rx_first = first;
      rx_data  = (i < 2) ? 8'hA5 : (i < 6) ? pay[i-2] : (i == 6) ? chkb : 8'h3C;
      if (i == 6 && first && !corrupt) begin
        last_ref = cyc + 1 + pd_now;
        exp_q.push_back(last_ref);
      end
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_first = 1'b0;
  endtask

  // Monitor: pops expected reference cycles as events appear.
  always @(negedge clk) begin
    if (rst_n && sync_evt) begin
      if (exp_q.size() == 0) begin
        unexp++; checks++; errors++;
        $display("FAIL R3/R4/R11: actual=sync_evt expected=none (cycle %0d)", cyc);
      end else begin
        chk("R5", cyc, exp_q.pop_front());
      end
    end
  end

  task automatic check_window(input int r);
    at_cycle(r + 1 + RTL - 1); chk("R7 rt before boundary", int'(rt_slot), 1);
    at_cycle(r + 1 + RTL);     chk("R7 rt at boundary", int'(rt_slot), 0);
    at_cycle(r + 1 + PST - 1); chk("R8 pulse before", int'(cyc_pulse), 0);
    at_cycle(r + 1 + PST);     chk("R8 pulse start", int'(cyc_pulse), 1);
    at_cycle(r + 1 + PST + PWD - 1); chk("R8 pulse last", int'(cyc_pulse), 1);
    at_cycle(r + 1 + PST + PWD);     chk("R8 pulse end", int'(cyc_pulse), 0);
    at_cycle(r + 1 + LEN - 1); chk("R6 last position", int'(rt_slot), 0);
    at_cycle(r + 1 + LEN);     chk("R6 wrap to zero", int'(rt_slot), 1);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    int ra, rb, u0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sync_evt", int'(sync_evt), 0);
    chk("R1 locked", int'(locked), 0);
    chk("R1 rt_slot", int'(rt_slot), 1);
    chk("R1 cyc_pulse", int'(cyc_pulse), 0);

    // R2 R5: good sync, zero delay
    send_frame(1'b1, 1'b0, 12, 8'h11);
    ra = last_ref;
    at_cycle(ra + 2);
    chk("R9 single ref no lock", int'(locked), 0);
    // R9: second good sync before any wrap
    send_frame(1'b1, 1'b0, 12, 8'h6B);
    rb = last_ref;
    at_cycle(rb + 3);
    chk("R9 locked after two", int'(locked), 1);
    check_window(rb);

    // R3: bad check byte ignored, timer free-runs
    u0 = unexp;
    send_frame(1'b1, 1'b1, 12, 8'h22);
    repeat (10) @(negedge clk);
    chk("R3 no event on bad crc", unexp, u0);
    at_cycle(rb + 1 + 2*LEN - 1); chk("R3 free-run last", int'(rt_slot), 0);
    at_cycle(rb + 1 + 2*LEN);     chk("R3 free-run wrap", int'(rt_slot), 1);

    // R4: non-first frame ignored
    send_frame(1'b0, 1'b0, 12, 8'h33);
    repeat (10) @(negedge clk);
    chk("R4 no event on other frame", unexp, u0);
    // R11: frame cut before check byte
    send_frame(1'b1, 1'b0, 5, 8'h44);
    repeat (10) @(negedge clk);
    chk("R11 no event on short frame", unexp, u0);

    // R10: three wraps with no reference
    at_cycle(rb + 3*LEN);     chk("R10 still locked", int'(locked), 1);
    at_cycle(rb + 3*LEN + 1); chk("R10 lock lost", int'(locked), 0);

    // R5: non-zero port delay
    cfg_port_delay = 16'd7; pd_now = 7;
    repeat (3) @(negedge clk);
    send_frame(1'b1, 1'b0, 12, 8'h5E);
    at_cycle(last_ref + RTL);     chk("R7 rt with delay", int'(rt_slot), 1);
    at_cycle(last_ref + RTL + 1); chk("R7 rt end with delay", int'(rt_slot), 0);

    repeat (20) @(negedge clk);
    chk("R2 all expected events seen", exp_q.size(), 0);
    done = 1'b1;
    summary();
  end

  always @(posedge clk) begin
    if (!done && cyc == 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
    end
  end

endmodule